// File: doc/BRIEF.md
# Two-Block I2C Serial EEPROM Slave

This block is a synthesizable I2C target that behaves like a byte-addressable serial EEPROM made of two 64 KB blocks. A master selects the device with a control byte, loads a 16-bit internal address, and then either stores data bytes or reads them back. The control byte carries the block-select bit, so the two blocks behave as two separate address spaces that share one bus address. Two strap inputs give the device its two hardware address bits, which lets two copies share one bus.

The bus lines are open-drain. The block receives the resolved SCL and SDA levels and returns a single output enable, `sdaOe`, which pulls SDA low while it is high. SCL is input-only because the block never stretches the clock. Both inputs are synchronised to the system clock, which must run well above the bus bit rate. The storage depth can be set by a parameter for simulation. Address bits above that depth alias, but the address counter and its wrap rules always work on the full 16 bits.

Top module: `i2cEeprom`

## Requirements
- R1: The block acknowledges a control byte only when bits 7..4 are 1010 and bits 2..1 equal `strap`. On any other control byte it leaves SDA released for the acknowledge slot and for every later byte until the next start condition, and memory is not changed.
- R2: A write transaction is made of a control byte with bit 0 = 0, an address high byte, an address low byte and then data bytes. Each of these bytes is acknowledged. Each data byte is stored at index {bit 3 of the control byte, address[ADDR_W-1:0]}.
- R3: Bit 3 of the control byte selects the block. The same 16-bit address in block 0 and in block 1 holds independent bytes.
- R4: During a multi-byte write, only the low 7 address bits advance. A write that passes the end of a 128-byte page continues at the start of that same page.
- R5: A random read is a control byte with bit 0 = 0, two address bytes, a repeated start and a control byte with bit 0 = 1. It returns the byte at that address, most significant bit first.
- R6: A sequential read advances the full 16-bit address for each byte that the master acknowledges. It does not stop at page edges, and it wraps from 0xFFFF to 0x0000 inside the selected block.
- R7: After the master leaves a read byte unacknowledged, the block keeps SDA released and sends no further data.
- R8: A start condition seen at any point makes the next byte a control byte. A stop condition seen at any point returns the block to idle. In both cases any partly received byte is discarded.
- R9: `sdaOe` changes only while SCL is low, except for being released at a start or stop condition.
- R10: While reset is held and just after it is released, `sdaOe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Resolved SCL line level |
| sdaIn | input | 1 | Resolved SDA line level |
| strap | input | 2 | Hardware address bits compared with control byte bits 2..1 |
| sdaOe | output | 1 | High pulls SDA low |

## Verification
The bench first runs a table of single-byte writes at matching addresses in both blocks, including 0x0000 and 0xFFFF, and then reads them all back with random reads. This shows that the two blocks are kept apart and that the stored address bytes are decoded correctly. A six-byte write starting four bytes before the end of a page is then read back as one sequential run across the page edge. This shows the write wrap and the read non-wrap side by side, since the run reaches a byte that was written earlier. A read starting at 0xFFFF in block 1 shows the 16-bit wrap staying inside the block. Control bytes with a wrong strap and with wrong fixed bits, and transactions cut off by a start or a stop in the middle of a byte, show what the block ignores or discards.

// File: rtl/i2cEepromPkg.sv
`timescale 1ns/1ps
package i2cEepromPkg;

  localparam logic [3:0] CTRL_TAG = 4'b1010;
  localparam int PAGE_W = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADRH,
    ST_ADRL,
    ST_WDAT,
    ST_RDAT
  } busState_t;

  typedef struct packed {
    logic shiftIn;
    logic setBlk;
    logic ldAdrHi;
    logic ldAdrLo;
    logic wrByte;
    logic ldTx;
    logic shTx;
    logic incRd;
  } dpStrobe_t;

endpackage

// File: rtl/i2cSlaveData.sv
`timescale 1ns/1ps
module i2cSlaveData
  import i2cEepromPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  strobe,
  input  logic       sdaBit,
  output logic [7:0] rxByte,
  output logic       txMsb
);

  localparam int IDX_W     = ADDR_W + 1;
  localparam int MEM_DEPTH = 2 ** IDX_W;

  logic [7:0]       mem [MEM_DEPTH];
  logic [7:0]       rxSr;
  logic [7:0]       txSr;
  logic [15:0]      addr;
  logic             blk;
  logic [IDX_W-1:0] idx;

  assign idx    = {blk, addr[ADDR_W-1:0]};
  assign rxByte = rxSr;
  assign txMsb  = txSr[7];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSr <= '0;
      txSr <= '0;
      addr <= '0;
      blk  <= 1'b0;
    end else begin
      if (strobe.shiftIn) rxSr <= {rxSr[6:0], sdaBit};
      if (strobe.setBlk)  blk <= rxSr[3];
      if (strobe.ldAdrHi) addr[15:8] <= rxSr;
      if (strobe.ldAdrLo) addr[7:0] <= rxSr;
      if (strobe.wrByte)  addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + 1'b1;
      if (strobe.incRd)   addr <= addr + 16'd1;
      if (strobe.ldTx)    txSr <= mem[idx];
      else if (strobe.shTx) txSr <= {txSr[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.wrByte) mem[idx] <= rxSr;
  end

  // R4: a write step keeps the page number
  a_r4_page_wrap: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrByte |=> addr[15:PAGE_W] == $past(addr[15:PAGE_W]));

  // R6: a read step advances the address and keeps the block
  a_r6_block_kept: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.incRd && !strobe.setBlk) |=> (blk == $past(blk)) && (addr == $past(addr) + 16'd1));

endmodule

// File: rtl/i2cSlaveCtrl.sv
`timescale 1ns/1ps
module i2cSlaveCtrl
  import i2cEepromPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [1:0] strap,
  input  logic [7:0] rxByte,
  input  logic       txMsb,
  output dpStrobe_t  strobe,
  output logic       sdaBit,
  output logic       sdaOe
);

  logic [1:0] sclSync, sdaSync;
  logic       sclP, sdaP, sclS, sdaS;
  logic       sclRise, sclFall, startDet, stopDet;
  busState_t  state, pendState;
  logic [3:0] bitCnt;
  logic       ackDrive, txActive;
  logic       ctrlOk, receiving, byteDone, ackEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclP    <= 1'b1;
      sdaP    <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclP    <= sclS;
      sdaP    <= sdaS;
    end
  end

  assign sclS     = sclSync[1];
  assign sdaS     = sdaSync[1];
  assign sdaBit   = sdaS;
  assign sclRise  = sclS & ~sclP;
  assign sclFall  = ~sclS & sclP;
  assign startDet = sclS & sclP & sdaP & ~sdaS;
  assign stopDet  = sclS & sclP & ~sdaP & sdaS;

  assign ctrlOk    = (rxByte[7:4] == CTRL_TAG) && (rxByte[2:1] == strap);
  assign receiving = (state == ST_CTRL) || (state == ST_ADRH) ||
                     (state == ST_ADRL) || (state == ST_WDAT);
  assign byteDone  = sclFall && (bitCnt == 4'd8) && !startDet && !stopDet;
  assign ackEnd    = sclFall && (bitCnt == 4'd9) && (state != ST_IDLE);

  always_comb begin
    strobe         = '0;
    strobe.shiftIn = sclRise && receiving && (bitCnt < 4'd8);
    strobe.setBlk  = byteDone && (state == ST_CTRL) && ctrlOk;
    strobe.ldAdrHi = byteDone && (state == ST_ADRH);
    strobe.ldAdrLo = byteDone && (state == ST_ADRL);
    strobe.wrByte  = byteDone && (state == ST_WDAT);
    strobe.incRd   = byteDone && (state == ST_RDAT);
    strobe.ldTx    = ackEnd && (pendState == ST_RDAT);
    strobe.shTx    = sclFall && (state == ST_RDAT) && (bitCnt >= 4'd1) && (bitCnt <= 4'd7);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      pendState <= ST_IDLE;
      bitCnt    <= '0;
      ackDrive  <= 1'b0;
      txActive  <= 1'b0;
    end else if (startDet || stopDet) begin
      state    <= startDet ? ST_CTRL : ST_IDLE;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      txActive <= 1'b0;
    end else if (state != ST_IDLE) begin
      if (sclRise) begin
        if (bitCnt < 4'd9) bitCnt <= bitCnt + 4'd1;
        if (bitCnt == 4'd8 && state == ST_RDAT)
          pendState <= sdaS ? ST_IDLE : ST_RDAT;
      end
      if (byteDone) begin
        unique case (state)
          ST_CTRL: begin
            if (ctrlOk) begin
              ackDrive  <= 1'b1;
              pendState <= rxByte[0] ? ST_RDAT : ST_ADRH;
            end else begin
              state  <= ST_IDLE;
              bitCnt <= '0;
            end
          end
          ST_ADRH: begin ackDrive <= 1'b1; pendState <= ST_ADRL; end
          ST_ADRL: begin ackDrive <= 1'b1; pendState <= ST_WDAT; end
          ST_WDAT: begin ackDrive <= 1'b1; pendState <= ST_WDAT; end
          default: txActive <= 1'b0;
        endcase
      end
      if (ackEnd) begin
        ackDrive <= 1'b0;
        bitCnt   <= '0;
        state    <= pendState;
        txActive <= (pendState == ST_RDAT);
      end
    end
  end

  assign sdaOe = ackDrive | (txActive & ~txMsb);

  // R1: nothing is driven while idle
  a_r1_idle_silent: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaOe);

  // R8: a start always leads to a fresh control byte
  a_r8_start_resets: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == ST_CTRL) && (bitCnt == 4'd0));

  // R8: a stop always leads to idle
  a_r8_stop_idles: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (state == ST_IDLE));

  // R9: SDA drive only moves while SCL is low
  a_r9_low_only: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && $past(sclS) && !$past(startDet) && !$past(stopDet)) |-> $stable(sdaOe));

  // R2: bit counter stays within one byte plus acknowledge
  a_r2_bitcnt_range: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= 4'd9);

endmodule

// File: rtl/i2cEeprom.sv
`timescale 1ns/1ps
module i2cEeprom
  import i2cEepromPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [1:0] strap,
  output logic       sdaOe
);

  dpStrobe_t  strobe;
  logic [7:0] rxByte;
  logic       txMsb;
  logic       sdaBit;

  i2cSlaveCtrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sclIn  (sclIn),
    .sdaIn  (sdaIn),
    .strap  (strap),
    .rxByte (rxByte),
    .txMsb  (txMsb),
    .strobe (strobe),
    .sdaBit (sdaBit),
    .sdaOe  (sdaOe)
  );

  i2cSlaveData #(.ADDR_W(ADDR_W)) u_data (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .sdaBit (sdaBit),
    .rxByte (rxByte),
    .txMsb  (txMsb)
  );

endmodule

// File: tb/test_i2cEeprom.sv
`timescale 1ns/1ps
module test_i2cEeprom;

  localparam int ADDR_W = 8;
  localparam logic [1:0] STRAP = 2'b10;
  localparam int NVEC = 7;
  // {block, address, data}
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b0, 16'h0000, 8'h33},
    {1'b1, 16'h0000, 8'h5A},
    {1'b1, 16'hFFFF, 8'hA5},
    {1'b0, 16'h1080, 8'hC3},
    {1'b0, 16'h0042, 8'h11},
    {1'b1, 16'h0042, 8'h22},
    {1'b0, 16'h00FF, 8'h99}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaOe;
  logic sdaLine;
  logic [7:0] model [2 ** (ADDR_W + 1)];
  int nChecks = 0;
  int nFails = 0;
  int viol = 0;
  bit done = 1'b0;
  logic prevScl = 1'b1;
  logic prevOe = 1'b0;

  assign sdaLine = sdaM & ~sdaOe;

  always #2.5 clk = ~clk;

  i2cEeprom #(.ADDR_W(ADDR_W)) i_i2cEeprom (
    .clk   (clk),
    .rstN  (rstN),
    .sclIn (sclM),
    .sdaIn (sdaLine),
    .strap (STRAP),
    .sdaOe (sdaOe)
  );

  always @(negedge clk) begin
    if (rstN && sclM && prevScl && (sdaOe != prevOe)) viol++;
    prevScl = sclM;
    prevOe  = sdaOe;
  end

  function automatic int idxOf(input logic b, input logic [15:0] a);
    return int'({b, a[ADDR_W-1:0]});
  endfunction

  function automatic logic [7:0] ctrlByte(input logic b, input logic rd);
    return {4'b1010, b, STRAP, rd};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startC();
    sdaM = 1'b1; tick(10);
    sclM = 1'b1; tick(10);
    sdaM = 1'b0; tick(10);
    sclM = 1'b0; tick(10);
  endtask

  task automatic stopC();
    sdaM = 1'b0; tick(10);
    sclM = 1'b1; tick(10);
    sdaM = 1'b1; tick(10);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b;    tick(10);
    sclM = 1'b1; tick(20);
    sclM = 1'b0; tick(10);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaM = 1'b1; tick(10);
    sclM = 1'b1; tick(10);
    ack = !sdaLine;
    tick(10);
    sclM = 1'b0; tick(10);
  endtask

  task automatic recvByte(input bit mAck, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      tick(10);
      sclM = 1'b1; tick(10);
      d[i] = sdaLine;
      tick(10);
      sclM = 1'b0; tick(10);
    end
    sdaM = !mAck; tick(10);
    sclM = 1'b1;  tick(20);
    sclM = 1'b0;  tick(5);
    sdaM = 1'b1;  tick(5);
  endtask

  task automatic wrSeq(input logic b, input logic [15:0] a, input int n,
                       input logic [7:0] base, output int acks);
    bit ack;
    acks = 0;
    startC();
    sendByte(ctrlByte(b, 1'b0), ack); acks += int'(ack);
    sendByte(a[15:8], ack);           acks += int'(ack);
    sendByte(a[7:0], ack);            acks += int'(ack);
    for (int i = 0; i < n; i++) begin
      sendByte(base + 8'(i), ack);    acks += int'(ack);
    end
    stopC();
  endtask

  task automatic rdSeq(input logic b, input logic [15:0] a, input int n,
                       output logic [7:0] got [8], output int acks);
    bit ack;
    acks = 0;
    startC();
    sendByte(ctrlByte(b, 1'b0), ack); acks += int'(ack);
    sendByte(a[15:8], ack);           acks += int'(ack);
    sendByte(a[7:0], ack);            acks += int'(ack);
    startC();
    sendByte(ctrlByte(b, 1'b1), ack); acks += int'(ack);
    for (int i = 0; i < n; i++) recvByte(i != n - 1, got[i]);
    stopC();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [7:0] got [8];
    logic [7:0] d;
    int acks;
    bit ack;
    int busy;

    // R10: reset state
    tick(20);
    chk("R10 sdaOe in reset", int'(sdaOe), 0);
    rstN = 1'b1;
    tick(20);
    chk("R10 sdaOe after reset", int'(sdaOe), 0);

    // R2: table of single-byte writes
    for (int v = 0; v < NVEC; v++) begin
      wrSeq(VEC[v][24], VEC[v][23:8], 1, VEC[v][7:0], acks);
      chk("R2 write acks", acks, 4);
      model[idxOf(VEC[v][24], VEC[v][23:8])] = VEC[v][7:0];
    end
    // R3, R5: random reads back, same addresses in both blocks
    for (int v = 0; v < NVEC; v++) begin
      rdSeq(VEC[v][24], VEC[v][23:8], 1, got, acks);
      chk("R5 read acks", acks, 4);
      chk("R3/R5 read data", int'(got[0]), int'(model[idxOf(VEC[v][24], VEC[v][23:8])]));
    end

    // R4: page write across the page end
    wrSeq(1'b0, 16'h107C, 6, 8'hE0, acks);
    chk("R4 page write acks", acks, 9);
    for (int i = 0; i < 6; i++)
      model[idxOf(1'b0, {9'h020, 7'(7'h7C + 7'(i))})] = 8'hE0 + 8'(i);
    rdSeq(1'b0, 16'h107C, 5, got, acks);
    for (int i = 0; i < 5; i++)
      chk("R4/R6 sequential read across page", int'(got[i]),
          int'(model[idxOf(1'b0, 16'h107C + 16'(i))]));
    rdSeq(1'b0, 16'h1000, 2, got, acks);
    chk("R4 wrapped byte 0", int'(got[0]), 32'hE4);
    chk("R4 wrapped byte 1", int'(got[1]), 32'hE5);

    // R6: 0xFFFF wraps to 0x0000 inside block 1
    rdSeq(1'b1, 16'hFFFF, 2, got, acks);
    chk("R6 byte at FFFF", int'(got[0]), 32'hA5);
    chk("R6 wrap stays in block", int'(got[1]), 32'h5A);

    // R7: no drive after master NACK
    startC();
    sendByte(ctrlByte(1'b1, 1'b0), ack);
    sendByte(8'h00, ack);
    sendByte(8'h42, ack);
    startC();
    sendByte(ctrlByte(1'b1, 1'b1), ack);
    recvByte(1'b0, d);
    chk("R7 byte before NACK", int'(d), 32'h22);
    busy = 0;
    for (int i = 0; i < 9; i++) begin
      sclM = 1'b1;
      for (int k = 0; k < 20; k++) begin tick(1); if (sdaOe) busy++; end
      sclM = 1'b0;
      for (int k = 0; k < 20; k++) begin tick(1); if (sdaOe) busy++; end
    end
    chk("R7 released after NACK", busy, 0);
    stopC();

    // R1: wrong strap and wrong fixed bits are ignored
    startC();
    sendByte({4'b1010, 1'b0, ~STRAP, 1'b0}, ack);
    chk("R1 wrong strap not acked", int'(ack), 0);
    sendByte(8'h00, ack);
    chk("R1 later byte not acked", int'(ack), 0);
    sendByte(8'h42, ack);
    sendByte(8'h77, ack);
    chk("R1 data byte not acked", int'(ack), 0);
    stopC();
    startC();
    sendByte({4'b1011, 1'b0, STRAP, 1'b0}, ack);
    chk("R1 wrong fixed bits not acked", int'(ack), 0);
    sendByte(8'h00, ack);
    sendByte(8'h42, ack);
    sendByte(8'h66, ack);
    stopC();
    rdSeq(1'b0, 16'h0042, 1, got, acks);
    chk("R1 memory untouched", int'(got[0]), 32'h11);

    // R8: stop in the middle of a data byte discards it
    startC();
    sendByte(ctrlByte(1'b0, 1'b0), ack);
    sendByte(8'h00, ack);
    sendByte(8'hFF, ack);
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    stopC();
    rdSeq(1'b0, 16'h00FF, 1, got, acks);
    chk("R8 stop mid-byte no write", int'(got[0]), 32'h99);

    // R8: start mid-byte makes the next byte a control byte
    startC();
    sendByte(ctrlByte(1'b0, 1'b0), ack);
    sendByte(8'h00, ack);
    sendBit(1'b1); sendBit(1'b1); sendBit(1'b0);
    startC();
    sendByte(ctrlByte(1'b0, 1'b1), ack);
    chk("R8 control after restart acked", int'(ack), 1);
    recvByte(1'b0, d);
    chk("R8 read after restart", int'(d), int'(model[idxOf(1'b0, 16'h0000)]));
    stopC();

    // R9: drive never moved while SCL high
    chk("R9 sdaOe changes only with SCL low", viol, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule